// File: doc/BRIEF.md
# Chip-Select Access Policy Unit

This block keeps a control word for each of eight chip-select regions on an external expansion bus and rules on every access that the bus bridge presents to it. For each access it decides in one registered step whether an external cycle may start, whether the access must be answered with an error, whether a write is thrown away, or whether the cycle has to be held off because an attached device is not ready. It also tells the sequencer downstream whether a read may be completed as a split transaction.

Software programs a region through a simple write port: region index plus a 32-bit word. Four fields of that word carry policy: a region enable, a write permission, a split permission and the polarity of the device-ready line. The four upper regions each have one external ready line. That line is consulted only when the bridge flags the region as being in DSP host-port mode. The ready lines arrive asynchronously and pass through a synchronizer before use. Region 0 leaves reset enabled but write-protected and with split reads forbidden, so a boot device answers plain reads at once and cannot be overwritten.

Top module: `acc_pol_top`

## Requirements
- R1: Bit 31 of a region's control word enables the region. An access to a region whose bit 31 is 0 raises `acc_err` and leaves `acc_go` low.
- R2: Bit 1 of a region's control word permits writes. A write to an enabled region whose bit 1 is 0 raises `acc_drop` (the write completes with an OKAY answer), with `acc_go`, `acc_err` and `acc_wait` all low.
- R3: Bit 3 of a region's control word permits split reads. `acc_split` is high only alongside `acc_go` for a read, and only when bit 3 of the addressed region is 1.
- R4: After reset all outputs are low. Region 0 is enabled, write-protected, split-disabled and has ready polarity low. Regions 1 to 7 reset with every policy field at 0.
- R5: Region 4+k uses ready line `dev_rdy[k]` (k = 0..3). That line affects an access only when `hpi_mode` for that region is 1. Regions 0 to 3, and upper regions in any other mode, ignore the ready lines.
- R6: Bit 5 of a region's control word sets the ready polarity: 0 means the device is ready when its line is 0, and 1 means it is ready when its line is 1.
- R7: An enabled, permitted access to a region whose ready line is consulted and not at its ready level raises `acc_wait`, with `acc_go` low.
- R8: Outputs appear on the clock edge that samples the access. A ready line is seen through a two-stage synchronizer, so the decision uses the line's value from two edges before the access edge.
- R9: A control write takes effect for accesses sampled on later edges. An access sampled on the same edge as the write sees the old word. A write changes only the region it indexes.
- R10: At most one of `acc_go`, `acc_err`, `acc_drop` and `acc_wait` is high in any cycle, and all four are low in the cycle after an edge with no valid access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_idx | input | 3 | Region index for the control write |
| cfg_wdata | input | 32 | Control word (bit 31 enable, bit 5 ready polarity, bit 3 split, bit 1 write permit) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_idx | input | 3 | Decoded region of the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| hpi_mode | input | 8 | Per-region DSP host-port mode flag |
| dev_rdy | input | 4 | Asynchronous device-ready lines for regions 4 to 7 |
| acc_go | output | 1 | Start the external cycle |
| acc_err | output | 1 | Answer the access with an error |
| acc_drop | output | 1 | Discard the write, answer OKAY |
| acc_split | output | 1 | The read may be split |
| acc_wait | output | 1 | Hold the access off |

## Verification
On every cycle the assertions check that the outcome signals never overlap and fall silent after an idle edge, that a split grant only accompanies a granted read, that a drop follows only a write, that a disabled region always draws an error, that a hold-off only arises for an upper region in host-port mode, and that the register bank comes out of reset with the boot values. Polarity handling, the two-edge latency of the ready synchronizer, the ordering of a control write against an access on the same edge, and isolation between regions can only be shown by the bench's scenarios, which compare every output each cycle against a behavioural model.

// File: rtl/acc_pol_pkg.sv
// Package: acc_pol_pkg
// Shared field positions, the stored policy record and the outcome encoding
// for the chip-select access policy unit.
// Assumes a 32-bit control word; only four bits of it carry policy.
package acc_pol_pkg;

    localparam int CTRL_W    = 32;
    localparam int EN_BIT    = 31;
    localparam int WR_BIT    = 1;
    localparam int SPLIT_BIT = 3;
    localparam int POL_BIT   = 5;

    localparam logic [CTRL_W-1:0] POLICY_MASK =
        (CTRL_W'(1) << EN_BIT) | (CTRL_W'(1) << WR_BIT) |
        (CTRL_W'(1) << SPLIT_BIT) | (CTRL_W'(1) << POL_BIT);

    // Decoded policy of one region
    typedef struct packed {
        logic en;
        logic wr_ok;
        logic split_ok;
        logic rdy_hi;
    } pol_flags_t;

    // Ruling on one access
    typedef enum logic [2:0] {
        OC_NONE = 3'd0,
        OC_GO   = 3'd1,
        OC_ERR  = 3'd2,
        OC_DROP = 3'd3,
        OC_WAIT = 3'd4
    } outcome_e;

    // Extract the policy fields from a control word
    function automatic pol_flags_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        pol_flags_t f;
        f.en       = w[EN_BIT];
        f.wr_ok    = w[WR_BIT];
        f.split_ok = w[SPLIT_BIT];
        f.rdy_hi   = w[POL_BIT];
        return f;
    endfunction

endpackage

// File: rtl/acc_pol_regbank.sv
// Module: acc_pol_regbank
// Holds the decoded policy of every region. A control write updates only the
// indexed region; the new value is visible from the next cycle on.
// Assumes: the boot region resets to BOOT_RST_CTRL, all others to zero.
module acc_pol_regbank
    import acc_pol_pkg::*;
#(
    parameter int                NUM_REGIONS   = 8,
    parameter int                IDX_W         = 3,
    parameter int                BOOT_REGION   = 0,
    parameter logic [CTRL_W-1:0] BOOT_RST_CTRL = 32'h8000_0000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [IDX_W-1:0]                   cfg_idx,
    input  logic [CTRL_W-1:0]                  cfg_wdata,
    output pol_flags_t [NUM_REGIONS-1:0]       flags
);

    localparam pol_flags_t BOOT_FLAGS = unpack_ctrl(BOOT_RST_CTRL);

    pol_flags_t wr_flags;
    logic       unused_cfg_bits;

    // Decode the incoming word once for all regions
    assign wr_flags        = unpack_ctrl(cfg_wdata);
    assign unused_cfg_bits = ^(cfg_wdata & ~POLICY_MASK);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam pol_flags_t RST_FLAGS = (g == BOOT_REGION) ? BOOT_FLAGS : '0;

        pol_flags_t flags_q;

        // Per-region policy storage with its own reset value
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q <= RST_FLAGS;
            end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                flags_q <= wr_flags;
            end
        end

        assign flags[g] = flags_q;

        AST_RESET_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (flags_q == RST_FLAGS)); // R4
    end

endmodule

// File: rtl/acc_pol_rdy_sync.sv
// Module: acc_pol_rdy_sync
// Brings the asynchronous device-ready lines into the clock domain through a
// chain of SYNC_STAGES flops. Assumes each line is a slow level signal.
module acc_pol_rdy_sync #(
    parameter int NUM_RDY     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_RDY-1:0] dev_rdy,
    output logic [NUM_RDY-1:0] rdy_s
);

    logic [SYNC_STAGES-1:0][NUM_RDY-1:0] stage_q;

    // Shift the ready lines through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= dev_rdy;
            for (int k = 1; k < SYNC_STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign rdy_s = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/acc_pol_decide.sv
// Module: acc_pol_decide
// Rules on one access per cycle from the addressed region's policy and, for
// the upper regions in host-port mode, its synchronized ready line. The
// ruling is registered. Assumes acc_idx is a valid region whenever acc_valid.
module acc_pol_decide
    import acc_pol_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3,
    parameter int NUM_RDY     = 4,
    parameter int RDY_BASE    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic [IDX_W-1:0]              acc_idx,
    input  logic                          acc_write,
    input  logic [NUM_REGIONS-1:0]        hpi_mode,
    input  pol_flags_t [NUM_REGIONS-1:0]  flags,
    input  logic [NUM_RDY-1:0]            rdy_s,
    output logic                          acc_go,
    output logic                          acc_err,
    output logic                          acc_drop,
    output logic                          acc_split,
    output logic                          acc_wait
);

    logic [NUM_REGIONS-1:0] line_ok;
    pol_flags_t             sel;
    outcome_e               oc_d, oc_q;
    logic                   split_d, split_q;

    // Per-region readiness: only upper regions in host-port mode consult a line
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_ready
        if (g >= RDY_BASE) begin : g_line
            assign line_ok[g] = !hpi_mode[g] || (rdy_s[g-RDY_BASE] == flags[g].rdy_hi);
        end else begin : g_noline
            assign line_ok[g] = 1'b1;
        end
    end

    if (RDY_BASE > 0) begin : g_unused_mode
        logic unused_mode_lo;
        assign unused_mode_lo = ^hpi_mode[RDY_BASE-1:0];
    end

    assign sel = flags[acc_idx];

    // Priority: disabled, then discarded write, then not ready, then go
    always_comb begin
        oc_d = OC_NONE;
        if (acc_valid) begin
            if (!sel.en) begin
                oc_d = OC_ERR;
            end else if (acc_write && !sel.wr_ok) begin
                oc_d = OC_DROP;
            end else if (!line_ok[acc_idx]) begin
                oc_d = OC_WAIT;
            end else begin
                oc_d = OC_GO;
            end
        end
        split_d = (oc_d == OC_GO) && !acc_write && sel.split_ok;
    end

    // Register the ruling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc_q    <= OC_NONE;
            split_q <= 1'b0;
        end else begin
            oc_q    <= oc_d;
            split_q <= split_d;
        end
    end

    assign acc_go    = (oc_q == OC_GO);
    assign acc_err   = (oc_q == OC_ERR);
    assign acc_drop  = (oc_q == OC_DROP);
    assign acc_wait  = (oc_q == OC_WAIT);
    assign acc_split = split_q;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_go, acc_err, acc_drop, acc_wait})); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(acc_valid)) |-> !(acc_go || acc_err || acc_drop || acc_wait)); // R10
    AST_SPLIT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_split |-> (acc_go && !$past(acc_write))); // R3
    AST_DROP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_drop |-> $past(acc_write)); // R2
    AST_ERR_ON_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_valid && !flags[acc_idx].en)) |-> acc_err); // R1
    AST_WAIT_UPPER_HPI: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wait |-> (($past(acc_idx) >= IDX_W'(RDY_BASE)) && $past(hpi_mode[acc_idx]))); // R5

endmodule

// File: rtl/acc_pol_top.sv
// Module: acc_pol_top
// Chip-select access policy unit: policy register bank, ready-line
// synchronizer and the registered access ruling.
// Assumes NUM_REGIONS is a power of two and the ready lines belong to the
// top NUM_RDY regions.
module acc_pol_top
    import acc_pol_pkg::*;
#(
    parameter int                NUM_REGIONS   = 8,
    parameter int                NUM_RDY       = 4,
    parameter int                SYNC_STAGES   = 2,
    parameter int                BOOT_REGION   = 0,
    parameter logic [CTRL_W-1:0] BOOT_RST_CTRL = 32'h8000_0000,
    localparam int               IDX_W         = $clog2(NUM_REGIONS),
    localparam int               RDY_BASE      = NUM_REGIONS - NUM_RDY
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [CTRL_W-1:0]      cfg_wdata,
    input  logic                   acc_valid,
    input  logic [IDX_W-1:0]       acc_idx,
    input  logic                   acc_write,
    input  logic [NUM_REGIONS-1:0] hpi_mode,
    input  logic [NUM_RDY-1:0]     dev_rdy,
    output logic                   acc_go,
    output logic                   acc_err,
    output logic                   acc_drop,
    output logic                   acc_split,
    output logic                   acc_wait
);

    pol_flags_t [NUM_REGIONS-1:0] flags;
    logic [NUM_RDY-1:0]           rdy_s;

    acc_pol_regbank #(
        .NUM_REGIONS   (NUM_REGIONS),
        .IDX_W         (IDX_W),
        .BOOT_REGION   (BOOT_REGION),
        .BOOT_RST_CTRL (BOOT_RST_CTRL)
    ) u_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .flags     (flags)
    );

    acc_pol_rdy_sync #(
        .NUM_RDY     (NUM_RDY),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_rdy (dev_rdy),
        .rdy_s   (rdy_s)
    );

    acc_pol_decide #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W),
        .NUM_RDY     (NUM_RDY),
        .RDY_BASE    (RDY_BASE)
    ) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_idx   (acc_idx),
        .acc_write (acc_write),
        .hpi_mode  (hpi_mode),
        .flags     (flags),
        .rdy_s     (rdy_s),
        .acc_go    (acc_go),
        .acc_err   (acc_err),
        .acc_drop  (acc_drop),
        .acc_split (acc_split),
        .acc_wait  (acc_wait)
    );

endmodule

// File: tb/acc_pol_top_bench.sv
// Bench for acc_pol_top: behavioural model compared on every clock plus
// directed checks at the interesting points.
module acc_pol_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_idx = '0;
    logic        acc_write = 1'b0;
    logic [7:0]  hpi_mode = '0;
    logic [3:0]  dev_rdy = '0;
    logic        acc_go, acc_err, acc_drop, acc_split, acc_wait;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_on = 0;
    string tag = "R4";

    // control word bits: 31 enable, 5 polarity, 3 split, 1 write permit
    localparam logic [31:0] W_EN = 32'h8000_0000;
    localparam logic [31:0] W_WR = 32'h0000_0002;
    localparam logic [31:0] W_SP = 32'h0000_0008;
    localparam logic [31:0] W_PH = 32'h0000_0020;

    always #2 clk = ~clk;

    acc_pol_top u_acc_pol_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_idx(acc_idx),
        .acc_write(acc_write), .hpi_mode(hpi_mode), .dev_rdy(dev_rdy),
        .acc_go(acc_go), .acc_err(acc_err), .acc_drop(acc_drop),
        .acc_split(acc_split), .acc_wait(acc_wait)
    );

    // ---------------- behavioural model ----------------
    bit m_en [8], m_wr [8], m_sp [8], m_ph [8];
    bit [3:0] h1, h2;
    bit e_go, e_err, e_drop, e_split, e_wait;
    int r;
    bit rdy_ok;

    always @(posedge clk) begin
        if (!rst_n) begin
            {e_go, e_err, e_drop, e_split, e_wait} = '0;
            for (int i = 0; i < 8; i++) begin
                m_en[i] = (i == 0); m_wr[i] = 0; m_sp[i] = 0; m_ph[i] = 0;
            end
            h1 = '0; h2 = '0;
        end else begin
            {e_go, e_err, e_drop, e_split, e_wait} = '0;
            if (acc_valid) begin
                r = int'(acc_idx);
                rdy_ok = 1;
                if (r >= 4 && hpi_mode[r]) rdy_ok = (h2[r-4] == m_ph[r]);
                if (!m_en[r]) e_err = 1;
                else if (acc_write && !m_wr[r]) e_drop = 1;
                else if (!rdy_ok) e_wait = 1;
                else begin e_go = 1; e_split = !acc_write && m_sp[r]; end
            end
            h2 = h1; h1 = dev_rdy;
            if (cfg_we) begin
                m_en[cfg_idx] = cfg_wdata[31]; m_wr[cfg_idx] = cfg_wdata[1];
                m_sp[cfg_idx] = cfg_wdata[3];  m_ph[cfg_idx] = cfg_wdata[5];
            end
        end
    end

    task automatic check1(input string name, input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, name, act, exp, $time);
        end
    endtask

    // Compare every output to the model on every falling edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            check1("go",    tag, acc_go,    e_go);
            check1("err",   tag, acc_err,   e_err);
            check1("drop",  tag, acc_drop,  e_drop);
            check1("split", tag, acc_split, e_split);
            check1("wait",  tag, acc_wait,  e_wait);
        end
    end

    // Directed check of all five outputs, hand-computed values
    task automatic expect5(input string req, input logic g, input logic e,
                           input logic d, input logic s, input logic w);
        check1("go",    req, acc_go,    g);
        check1("err",   req, acc_err,   e);
        check1("drop",  req, acc_drop,  d);
        check1("split", req, acc_split, s);
        check1("wait",  req, acc_wait,  w);
    endtask

    task automatic cfg(input int idx, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = w;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // One access; returns at the negedge after its sampling edge
    task automatic access(input int idx, input logic wr);
        @(negedge clk);
        acc_valid = 1; acc_idx = 3'(idx); acc_write = wr;
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        cmp_on = 1;
        tag = "R4";
        expect5("R4 reset outputs", 0, 0, 0, 0, 0);
        rst_n = 1;
        idle(2);
        expect5("R10 idle", 0, 0, 0, 0, 0);

        // Boot region defaults
        access(0, 0); expect5("R4 region0 read", 1, 0, 0, 0, 0);
        access(0, 1); expect5("R4 R2 region0 write dropped", 0, 0, 1, 0, 0);
        access(1, 0); expect5("R4 R1 region1 disabled", 0, 1, 0, 0, 0);
        access(7, 1); expect5("R4 R1 region7 disabled", 0, 1, 0, 0, 0);

        // Enable region 1 fully
        tag = "R3";
        cfg(1, W_EN | W_WR | W_SP);
        access(1, 0); expect5("R3 split read", 1, 0, 0, 1, 0);
        access(1, 1); expect5("R2 R3 permitted write, no split", 1, 0, 0, 0, 0);
        access(0, 1); expect5("R9 region0 unaffected", 0, 0, 1, 0, 0);

        // Region 2: enable without write permit; same-edge write ordering
        tag = "R9";
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'd2; cfg_wdata = W_EN;
        acc_valid = 1; acc_idx = 3'd2; acc_write = 0;
        @(negedge clk);
        cfg_we = 0; acc_valid = 0;
        expect5("R9 same edge sees old word", 0, 1, 0, 0, 0);
        access(2, 0); expect5("R9 new word next cycle", 1, 0, 0, 0, 0);
        tag = "R2";
        access(2, 1); expect5("R2 write to protected region", 0, 0, 1, 0, 0);

        // Back-to-back accesses with alternating outcomes
        tag = "R10";
        @(negedge clk); acc_valid = 1; acc_idx = 3'd1; acc_write = 0;
        @(negedge clk); acc_idx = 3'd3;
        @(negedge clk); acc_idx = 3'd2; acc_write = 1;
        @(negedge clk); acc_valid = 0;
        idle(1);

        // Region 5, host-port mode, ready active low on dev_rdy[1]
        tag = "R7";
        cfg(5, W_EN | W_WR);
        hpi_mode = 8'b0010_0000;
        dev_rdy = 4'b0010;
        idle(3);
        access(5, 0); expect5("R7 not ready holds off", 0, 0, 0, 0, 1);
        tag = "R8";
        @(negedge clk); dev_rdy = 4'b0000;
        acc_valid = 1; acc_idx = 3'd5; acc_write = 0;
        @(negedge clk); expect5("R8 sync edge 1 still waits", 0, 0, 0, 0, 1);
        @(negedge clk); expect5("R8 sync edge 2 still waits", 0, 0, 0, 0, 1);
        @(negedge clk); expect5("R8 ready after two edges", 1, 0, 0, 0, 0);
        acc_valid = 0;
        idle(1);

        // Polarity high
        tag = "R6";
        cfg(5, W_EN | W_WR | W_PH);
        access(5, 1); expect5("R6 high polarity, line low waits", 0, 0, 0, 0, 1);
        dev_rdy = 4'b0010; idle(3);
        access(5, 1); expect5("R6 high polarity, line high goes", 1, 0, 0, 0, 0);

        // Mode off ignores the line; lower regions ignore lines
        tag = "R5";
        dev_rdy = 4'b0000; idle(3);
        hpi_mode = 8'b0000_0000;
        access(5, 0); expect5("R5 mode off ignores line", 1, 0, 0, 0, 0);
        hpi_mode = 8'b0000_0110; dev_rdy = 4'b1111; idle(3);
        access(1, 0); expect5("R5 lower region ignores lines", 1, 0, 0, 1, 0);
        hpi_mode = 8'b1000_0000;
        cfg(7, W_EN | W_SP);
        access(7, 0); expect5("R5 R6 region7 uses dev_rdy[3] low polarity", 0, 0, 0, 0, 1);
        dev_rdy = 4'b0111; idle(3);
        access(7, 0); expect5("R5 region7 ready, split read", 1, 0, 0, 1, 0);
        access(7, 1); expect5("R2 protected write skips wait", 0, 0, 1, 0, 0);

        // Disable boot region
        tag = "R1";
        cfg(0, 32'h0000_002A);
        access(0, 0); expect5("R1 region0 disabled", 0, 1, 0, 0, 0);
        access(1, 0); expect5("R9 region1 unaffected", 1, 0, 0, 1, 0);

        tag = "R4";
        @(negedge clk); rst_n = 0;
        idle(2);
        rst_n = 1;
        access(1, 0); expect5("R4 re-reset region1 disabled", 0, 1, 0, 0, 0);
        access(0, 0); expect5("R4 re-reset region0 enabled", 1, 0, 0, 0, 0);
        idle(2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule